// File: doc/BRIEF.md
# Hex Display Store Queue

This unit sits at the memory-mapped output for a bank of hex LED displays in a dual-issue core. Both issue pipes, A and B, can present a store in the same cycle. Each display has its own small ordering queue. When both pipes hit one display in one cycle, the unit keeps both stores and places the pipe A store first. Each queue moves at most one store per cycle into its display register.

A read port returns the newest value accepted for the display it selects. If that value is still waiting in the queue, the read returns the queued value rather than the register.

When any queue is close to full, the unit raises a stall back to the pipes. Stores presented while the stall is high are dropped, and the pipeline is expected to replay them.

Top module: `hexdisp_store_queue`

## Requirements
- R1: After reset every display output is zero, every queue is empty, `st_stall` is low and `rd_data` is zero.
- R2: The display is chosen by address bits [3:2] (value 0 to 3). Address bits [1:0] have no effect on which display is written or read.
- R3: A store accepted into an empty queue reaches its display output on the second rising edge after it is presented. A queue moves at most one store per cycle into its display.
- R4: When both pipes store to the same display in one cycle, both stores are kept. The pipe A value appears on the display first, and the pipe B value appears one cycle later.
- R5: `st_stall` is high whenever any queue holds DEPTH-1 or more entries. Stores presented while `st_stall` is high are discarded and never reach any display.
- R6: Stores from the two pipes to different displays in the same cycle are handled independently. Both displays update on the same edge.
- R7: From the cycle after acceptance, `rd_data` for a display equals the newest accepted value for that display, even while that value is still queued.
- R8: No queue ever holds more than DEPTH entries, and queued stores reach the display in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_st_valid | input | 1 | Pipe A store request |
| a_st_addr | input | ADDR_W | Pipe A store address within the display range |
| a_st_data | input | DATA_W | Pipe A store data |
| b_st_valid | input | 1 | Pipe B store request |
| b_st_addr | input | ADDR_W | Pipe B store address within the display range |
| b_st_data | input | DATA_W | Pipe B store data |
| rd_addr | input | ADDR_W | Read address within the display range |
| rd_data | output | DATA_W | Newest value for the display selected by `rd_addr` |
| st_stall | output | 1 | Stall back to both pipes; stores are dropped while high |
| disp_out | output | NUM_DISP*DATA_W | Display registers; display d sits at bits [d*DATA_W +: DATA_W] |

## Verification
Inputs are driven just after a falling edge, so the next rising edge captures them. From there:
- The newest value is due on `rd_data` one rising edge later.
- The display output for a store into an empty queue is due two rising edges later.
- For the second store of a same-cycle pair, the display output is due three rising edges later.

Each check waits the matching number of falling edges before it samples. Two kinds of check sample one edge early on purpose: the display must still hold its old value while `rd_data` already shows the new one.

`st_stall` depends only on the registered queue levels. It is therefore sampled in the same falling-edge window in which a store is presented, which lets the bench decide whether that store counts.

// File: rtl/hexq_pkg.sv
package hexq_pkg;
    // Default geometry shared by the display queue blocks
    parameter int unsigned HEXQ_NUM_DISP = 4;
    parameter int unsigned HEXQ_DATA_W   = 32;
    parameter int unsigned HEXQ_DEPTH    = 4;
    parameter int unsigned HEXQ_ADDR_W   = 4;
    parameter int unsigned HEXQ_SEL_LSB  = 2;
endpackage

// File: rtl/hexq_router.sv
module hexq_router #(
    parameter int unsigned NUM_DISP = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned SEL_LSB  = 2
) (
    input  logic                             accept_en,
    input  logic                             a_valid,
    input  logic [ADDR_W-1:0]                a_addr,
    input  logic [DATA_W-1:0]                a_data,
    input  logic                             b_valid,
    input  logic [ADDR_W-1:0]                b_addr,
    input  logic [DATA_W-1:0]                b_data,
    output logic [NUM_DISP-1:0]              push0,
    output logic [NUM_DISP-1:0][DATA_W-1:0]  data0,
    output logic [NUM_DISP-1:0]              push1,
    output logic [NUM_DISP-1:0][DATA_W-1:0]  data1
);
    localparam int unsigned SEL_W = (NUM_DISP > 1) ? $clog2(NUM_DISP) : 1;

    logic [SEL_W-1:0] a_sel;
    logic [SEL_W-1:0] b_sel;

    assign a_sel = a_addr[SEL_LSB +: SEL_W];
    assign b_sel = b_addr[SEL_LSB +: SEL_W];

    for (genvar d = 0; d < NUM_DISP; d++) begin : g_lane
        logic hit_a;
        logic hit_b;
        assign hit_a = accept_en && a_valid && (a_sel == SEL_W'(d));
        assign hit_b = accept_en && b_valid && (b_sel == SEL_W'(d));
        // Lane 0 always carries the older store; pipe A wins when both hit
        assign push0[d] = hit_a || hit_b;
        assign data0[d] = hit_a ? a_data : b_data;
        assign push1[d] = hit_a && hit_b;
        assign data1[d] = b_data;
    end
endmodule

// File: rtl/hexq_fifo.sv
module hexq_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push0,
    input  logic [DATA_W-1:0] data0,
    input  logic              push1,
    input  logic [DATA_W-1:0] data1,
    input  logic              pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    output logic [DATA_W-1:0] newest_data,
    output logic [CNT_W-1:0]  level
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
    endfunction

    always_comb begin
        logic [PTR_W-1:0] w;
        logic             pop_eff;
        st_d    = st_q;
        pop_eff = pop && (st_q.cnt != '0);
        if (pop_eff) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        w = st_q.wr;
        if (push0) begin
            st_d.mem[w] = data0;
            w           = ptr_inc(w);
        end
        if (push1) begin
            st_d.mem[w] = data1;
            w           = ptr_inc(w);
        end
        st_d.wr  = w;
        st_d.cnt = st_q.cnt + CNT_W'(push0) + CNT_W'(push1) - CNT_W'(pop_eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid  = (st_q.cnt != '0);
    assign head_data   = st_q.mem[st_q.rd];
    assign newest_data = st_q.mem[ptr_dec(st_q.wr)];
    assign level       = st_q.cnt;
endmodule

// File: rtl/hexdisp_store_queue.sv
module hexdisp_store_queue
    import hexq_pkg::*;
#(
    parameter int unsigned NUM_DISP = HEXQ_NUM_DISP,
    parameter int unsigned DATA_W   = HEXQ_DATA_W,
    parameter int unsigned DEPTH    = HEXQ_DEPTH,
    parameter int unsigned ADDR_W   = HEXQ_ADDR_W,
    parameter int unsigned SEL_LSB  = HEXQ_SEL_LSB
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         a_st_valid,
    input  logic [ADDR_W-1:0]            a_st_addr,
    input  logic [DATA_W-1:0]            a_st_data,
    input  logic                         b_st_valid,
    input  logic [ADDR_W-1:0]            b_st_addr,
    input  logic [DATA_W-1:0]            b_st_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         st_stall,
    output logic [NUM_DISP*DATA_W-1:0]   disp_out
);
    localparam int unsigned SEL_W = (NUM_DISP > 1) ? $clog2(NUM_DISP) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NUM_DISP-1:0][DATA_W-1:0] disp;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_DISP-1:0]              push0, push1;
    logic [NUM_DISP-1:0][DATA_W-1:0]  data0, data1;
    logic [NUM_DISP-1:0]              head_valid;
    logic [NUM_DISP-1:0][DATA_W-1:0]  head_data;
    logic [NUM_DISP-1:0][DATA_W-1:0]  newest_data;
    logic [NUM_DISP-1:0][CNT_W-1:0]   occ;
    logic [NUM_DISP-1:0]              near_full;
    logic [SEL_W-1:0]                 rd_sel;

    hexq_router #(
        .NUM_DISP (NUM_DISP),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .SEL_LSB  (SEL_LSB)
    ) u_router (
        .accept_en (!st_stall),
        .a_valid   (a_st_valid),
        .a_addr    (a_st_addr),
        .a_data    (a_st_data),
        .b_valid   (b_st_valid),
        .b_addr    (b_st_addr),
        .b_data    (b_st_data),
        .push0     (push0),
        .data0     (data0),
        .push1     (push1),
        .data1     (data1)
    );

    for (genvar d = 0; d < NUM_DISP; d++) begin : g_disp
        hexq_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk         (clk),
            .rst_n       (rst_n),
            .push0       (push0[d]),
            .data0       (data0[d]),
            .push1       (push1[d]),
            .data1       (data1[d]),
            .pop         (head_valid[d]),
            .head_valid  (head_valid[d]),
            .head_data   (head_data[d]),
            .newest_data (newest_data[d]),
            .level       (occ[d])
        );
        assign near_full[d] = (occ[d] >= CNT_W'(DEPTH - 1));
        assign disp_out[d*DATA_W +: DATA_W] = st_q.disp[d];
    end

    always_comb begin
        st_d = st_q;
        for (int d = 0; d < NUM_DISP; d++) begin
            if (head_valid[d]) begin
                st_d.disp[d] = head_data[d];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_stall = |near_full;
    assign rd_sel   = rd_addr[SEL_LSB +: SEL_W];
    assign rd_data  = (occ[rd_sel] != '0) ? newest_data[rd_sel] : st_q.disp[rd_sel];
endmodule

// File: rtl/hexq_checker.sv
module hexq_checker #(
    parameter int unsigned NUM_DISP = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned SEL_LSB  = 2,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
    localparam int unsigned SEL_W   = (NUM_DISP > 1) ? $clog2(NUM_DISP) : 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            st_stall,
    input logic [NUM_DISP*DATA_W-1:0]      disp_out,
    input logic [ADDR_W-1:0]               rd_addr,
    input logic [DATA_W-1:0]               rd_data,
    input logic [NUM_DISP-1:0][CNT_W-1:0]  occ
);
    logic [SEL_W-1:0] sel;
    assign sel = rd_addr[SEL_LSB +: SEL_W];

    for (genvar d = 0; d < NUM_DISP; d++) begin : g_chk
        // R8: queue level bounded by its depth
        a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            int'(occ[d]) <= int'(DEPTH));
        // R3: at most one entry leaves a queue per cycle
        a_r3_single_drain: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (int'(occ[d]) + 1 >= int'($past(occ[d]))));
        // R3: a display only changes when its queue held something
        a_r3_disp_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(disp_out[d*DATA_W +: DATA_W]) |-> ($past(occ[d]) != '0));
        // R5: nothing is added to a queue while stalled
        a_r5_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            st_stall |=> (int'(occ[d]) <= int'($past(occ[d]))));
    end

    // R7: with an empty queue the read returns the display register
    a_r7_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (occ[sel] == '0) |-> (rd_data == disp_out[int'(sel)*DATA_W +: DATA_W]));
endmodule

bind hexdisp_store_queue hexq_checker #(
    .NUM_DISP (NUM_DISP),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W),
    .SEL_LSB  (SEL_LSB)
) u_hexq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_stall (st_stall),
    .disp_out (disp_out),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .occ      (occ)
);

// File: tb/hexdisp_store_queue_test.sv
module hexdisp_store_queue_test;
    localparam int unsigned NUM_DISP = 4;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 4;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic                       a_st_valid, b_st_valid;
    logic [ADDR_W-1:0]          a_st_addr, b_st_addr, rd_addr;
    logic [DATA_W-1:0]          a_st_data, b_st_data, rd_data;
    logic                       st_stall;
    logic [NUM_DISP*DATA_W-1:0] disp_out;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hexdisp_store_queue uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_st_valid (a_st_valid),
        .a_st_addr  (a_st_addr),
        .a_st_data  (a_st_data),
        .b_st_valid (b_st_valid),
        .b_st_addr  (b_st_addr),
        .b_st_data  (b_st_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .st_stall   (st_stall),
        .disp_out   (disp_out)
    );

    function automatic logic [DATA_W-1:0] disp(input int d);
        return disp_out[d*DATA_W +: DATA_W];
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic av, input logic [ADDR_W-1:0] aa, input logic [DATA_W-1:0] ad,
                         input logic bv, input logic [ADDR_W-1:0] ba, input logic [DATA_W-1:0] bd);
        a_st_valid = av; a_st_addr = aa; a_st_data = ad;
        b_st_valid = bv; b_st_addr = ba; b_st_data = bd;
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int d = 0; d < NUM_DISP; d++) chk("R1 display zero", disp(d), '0);
        chk("R1 stall low", {31'd0, st_stall}, 32'd0);
        rd_addr = 4'h4;
        #1 chk("R1 read zero", rd_data, '0);
    endtask

    task automatic t_single();
        // R3/R7: pipe A alone to display 2
        rd_addr = 4'h8;
        drive(1'b1, 4'h8, 32'hA5A5_0001, 1'b0, '0, '0);
        wait_n(1); idle();
        chk("R7 queued value readable", rd_data, 32'hA5A5_0001);
        chk("R3 display not yet updated", disp(2), '0);
        wait_n(1);
        chk("R3 display after two edges", disp(2), 32'hA5A5_0001);
        chk("R7 read after drain", rd_data, 32'hA5A5_0001);
    endtask

    task automatic t_low_bits();
        // R2: address 0x7 has bits[3:2]=01 so it targets display 1
        rd_addr = 4'h6;
        drive(1'b0, '0, '0, 1'b1, 4'h7, 32'h1234_5678);
        wait_n(1); idle(); wait_n(1);
        chk("R2 display 1 written", disp(1), 32'h1234_5678);
        chk("R2 display 0 untouched", disp(0), '0);
        chk("R2 read ignores low bits", rd_data, 32'h1234_5678);
    endtask

    task automatic t_same_pair();
        // R4: both pipes to display 0
        rd_addr = 4'h1;
        drive(1'b1, 4'h0, 32'h0000_AAAA, 1'b1, 4'h2, 32'h0000_BBBB);
        wait_n(1); idle();
        chk("R7 newest is pipe B", rd_data, 32'h0000_BBBB);
        wait_n(1);
        chk("R4 pipe A first", disp(0), 32'h0000_AAAA);
        wait_n(1);
        chk("R4 pipe B second", disp(0), 32'h0000_BBBB);
        wait_n(2);
        chk("R4 display holds", disp(0), 32'h0000_BBBB);
    endtask

    task automatic t_diff_pair();
        // R6: pipe A to display 3, pipe B to display 1, same cycle
        rd_addr = 4'hC;
        drive(1'b1, 4'hC, 32'hCAFE_0003, 1'b1, 4'h4, 32'hCAFE_0001);
        wait_n(1); idle();
        chk("R6 read display 3 queued", rd_data, 32'hCAFE_0003);
        wait_n(1);
        chk("R6 display 3", disp(3), 32'hCAFE_0003);
        chk("R6 display 1", disp(1), 32'hCAFE_0001);
    endtask

    task automatic t_stall();
        // R5/R8: back-to-back pairs into display 2 fill the queue
        rd_addr = 4'h8;
        chk("R5 no stall before burst", {31'd0, st_stall}, 32'd0);
        drive(1'b1, 4'h8, 32'h5100_000A, 1'b1, 4'h8, 32'h5100_000B);
        wait_n(1);
        chk("R5 no stall at level 2", {31'd0, st_stall}, 32'd0);
        drive(1'b1, 4'h8, 32'h5200_000A, 1'b1, 4'h8, 32'h5200_000B);
        wait_n(1);
        chk("R5 stall at level 3", {31'd0, st_stall}, 32'd1);
        drive(1'b1, 4'h8, 32'h5300_000A, 1'b1, 4'h8, 32'h5300_000B);
        wait_n(1); idle();
        chk("R8 first entries in order", disp(2), 32'h5100_000B);
        chk("R5 dropped store not visible", rd_data, 32'h5200_000B);
        wait_n(1);
        chk("R8 third entry", disp(2), 32'h5200_000A);
        wait_n(4);
        chk("R5 dropped store never shown", disp(2), 32'h5200_000B);
        chk("R5 stall released", {31'd0, st_stall}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rd_addr = '0;
        idle();
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_single();
        t_low_bits();
        t_same_pair();
        t_diff_pair();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule